// File: doc/BRIEF.md
# Sequential Decimal Reciprocal Unit

This block takes an unsigned integer written as packed BCD digits and returns its reciprocal, also in packed BCD. It never converts to binary. It first moves the operand left one digit at a time until the most significant digit is non-zero, and it counts how many digits it moved. It then divides a remainder that starts at one by the normalised operand, in the way long division is done by hand. Each quotient digit is the number of times the divisor can be taken from the remainder. After each digit the remainder moves up one decimal place.

A caller pulses `start` with the operand on `t_bcd` and waits for the one-cycle `done` pulse. The result is read as 1/T ≈ `q_bcd` · 10^(`shift_exp` − (N_DIG−1) − (M_DIG−1)). `q_bcd` is the truncated value floor(10^(N_DIG+M_DIG−2) / (T·10^`shift_exp`)). A zero operand is rejected through `zero_err`. Each clock performs at most one decimal subtraction of N_DIG+1 digits, which keeps the combinational path short.

Top module: `bcd_reciprocal`

## Requirements
- R1: When `start` is accepted with `t_bcd` equal to zero, `done` and `zero_err` are high in the next cycle, and `q_bcd` and `shift_exp` are both zero.
- R2: For a non-zero operand, `shift_exp` at `done` equals the number of leading zero digits of `t_bcd`. Digit 0 is bits [3:0] and is the least significant.
- R3: For a non-zero operand T, `q_bcd` at `done` holds floor(10^(N_DIG+M_DIG−2) / (T·10^shift_exp)) as M_DIG packed BCD digits, least significant digit in bits [3:0].
- R4: `done` is high for exactly one cycle. `busy` is low in that cycle.
- R5: A `start` that arrives while `busy` is high is ignored. The result that follows belongs to the operand that was accepted.
- R6: While the unit is idle and `start` is low, `q_bcd`, `shift_exp` and `zero_err` keep their values.
- R7: `done` follows the accepting `start` edge within N_DIG + 1 + 10·M_DIG cycles.
- R8: Every 4-bit digit of `q_bcd` is a valid decimal digit (0 to 9).
- R9: After a non-zero operand is accepted, `busy` is high in the next cycle. `zero_err` reads zero at the `done` of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the unit is idle |
| t_bcd | input | 4*N_DIG | Operand, packed BCD |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_err | output | 1 | Operand was zero |
| q_bcd | output | 4*M_DIG | Quotient digits, packed BCD |
| shift_exp | output | $clog2(N_DIG+1) | Leading-zero digits removed while normalising |

## Verification
Several internal faults show up at the ports as soon as `done` fires. A wrong borrow or decimal correction in the subtractor, or a miscounted quotient digit, shows as a wrong digit or a non-decimal nibble in `q_bcd`. A remainder shift applied at the wrong time does the same. A normalisation that stops one digit early or late changes `shift_exp`, and through the divisor scale it also changes every quotient digit. A control state that fails to return to idle shows as a missing `done` within the latency bound, or as a `done` longer than one cycle. A register that is loaded while the unit is idle shows as a change in the held outputs before the next start.

// File: rtl/bcd_recip_pkg.sv
package bcd_recip_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_DIV  = 2'd2
  } recip_state_t;
endpackage

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       bin,
  output logic [3:0] d,
  output logic       bout
);
  logic [4:0] raw;

  always_comb begin
    raw = {1'b0, a} - {1'b0, b} - {4'b0, bin};
    if (raw[4]) begin
      d    = raw[3:0] + 4'd10;
      bout = 1'b1;
    end else begin
      d    = raw[3:0];
      bout = 1'b0;
    end
  end

  // R8: a valid decimal pair always yields a valid decimal digit
  always_comb begin
    if (a <= 4'd9 && b <= 4'd9)
      p_digit_valid_r8: assert (d <= 4'd9);
  end
endmodule

// File: rtl/bcd_sub_vec.sv
module bcd_sub_vec #(
  parameter int DIGITS = 5
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  output logic [4*DIGITS-1:0] diff,
  output logic                borrow
);
  logic [DIGITS:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit_sub u_cell (
      .a    (a[4*g +: 4]),
      .b    (b[4*g +: 4]),
      .bin  (chain[g]),
      .d    (diff[4*g +: 4]),
      .bout (chain[g+1])
    );
  end

  assign borrow = chain[DIGITS];
endmodule

// File: rtl/bcd_reciprocal.sv
module bcd_reciprocal
  import bcd_recip_pkg::*;
#(
  parameter int N_DIG = 4,
  parameter int M_DIG = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [4*N_DIG-1:0]         t_bcd,
  output logic                       busy,
  output logic                       done,
  output logic                       zero_err,
  output logic [4*M_DIG-1:0]         q_bcd,
  output logic [$clog2(N_DIG+1)-1:0] shift_exp
);
  localparam int TW   = DIGIT_W * N_DIG;
  localparam int QW   = DIGIT_W * M_DIG;
  localparam int RDIG = N_DIG + 1;
  localparam int RW   = DIGIT_W * RDIG;
  localparam int EW   = $clog2(N_DIG + 1);
  localparam int CW   = $clog2(M_DIG + 1);
  localparam logic [RW-1:0] REM_ONE = RW'(1) << (DIGIT_W * (N_DIG - 1));

  recip_state_t state;
  logic [TW-1:0] div_r;
  logic [RW-1:0] rem_r;
  logic [QW-1:0] qacc;
  logic [3:0]    qd;
  logic [CW-1:0] dcnt;
  logic [EW-1:0] zcnt;

  logic [RW-1:0] sub_diff;
  logic          sub_borrow;
  logic [QW-1:0] q_next;
  logic          t_is_zero;

  assign t_is_zero = (t_bcd == '0);
  assign q_next    = (qacc << DIGIT_W) | QW'(qd);
  assign busy      = (state != ST_IDLE);

  bcd_sub_vec #(.DIGITS(RDIG)) u_sub (
    .a      (rem_r),
    .b      ({4'h0, div_r}),
    .diff   (sub_diff),
    .borrow (sub_borrow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      div_r     <= '0;
      rem_r     <= '0;
      qacc      <= '0;
      qd        <= '0;
      dcnt      <= '0;
      zcnt      <= '0;
      done      <= 1'b0;
      zero_err  <= 1'b0;
      q_bcd     <= '0;
      shift_exp <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (t_is_zero) begin
              zero_err  <= 1'b1;
              done      <= 1'b1;
              q_bcd     <= '0;
              shift_exp <= '0;
            end else begin
              zero_err <= 1'b0;
              div_r    <= t_bcd;
              rem_r    <= REM_ONE;
              qacc     <= '0;
              qd       <= '0;
              dcnt     <= '0;
              zcnt     <= '0;
              state    <= ST_NORM;
            end
          end
        end
        ST_NORM: begin
          if (div_r[TW-1 -: 4] == 4'h0) begin
            div_r <= div_r << DIGIT_W;
            zcnt  <= zcnt + 1'b1;
          end else begin
            state <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (!sub_borrow) begin
            rem_r <= sub_diff;
            qd    <= qd + 4'd1;
          end else begin
            rem_r <= rem_r << DIGIT_W;
            qacc  <= q_next;
            qd    <= 4'd0;
            dcnt  <= dcnt + 1'b1;
            if (dcnt == CW'(M_DIG - 1)) begin
              q_bcd     <= q_next;
              shift_exp <= zcnt;
              done      <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a zero operand is flagged on the very next cycle
  p_zero_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && t_is_zero) |=> (done && zero_err));

  // R2: normalisation never removes more digits than a non-zero operand can have
  p_norm_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORM) |-> (zcnt <= EW'(N_DIG - 1)));

  // R3: the remainder stays below the divisor when a digit closes
  p_rem_top_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIV && sub_borrow) |-> (rem_r[RW-1 -: 4] == 4'h0));

  // R4: completion is a single-cycle pulse while idle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: results hold while idle without start
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(q_bcd) && $stable(shift_exp) && $stable(zero_err)));

  // R8: a digit count never passes nine
  p_digit_cap_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIV) |-> (qd <= 4'd9));

  // R9: a non-zero operand makes the unit busy
  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !t_is_zero) |=> busy);
endmodule

// File: tb/tb_bcd_reciprocal.sv
module tb_bcd_reciprocal;
  localparam int N_DIG = 4;
  localparam int M_DIG = 6;
  localparam int TW = 4 * N_DIG;
  localparam int QW = 4 * M_DIG;
  localparam int EW = $clog2(N_DIG + 1);
  localparam int LAT_MAX = N_DIG + 1 + 10 * M_DIG;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [TW-1:0] t_bcd;
  logic busy, done, zero_err;
  logic [QW-1:0] q_bcd;
  logic [EW-1:0] shift_exp;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bcd_reciprocal #(.N_DIG(N_DIG), .M_DIG(M_DIG)) dut (
    .clk(clk), .rst(rst), .start(start), .t_bcd(t_bcd),
    .busy(busy), .done(done), .zero_err(zero_err),
    .q_bcd(q_bcd), .shift_exp(shift_exp)
  );

  function automatic longint pow10(input int e);
    longint r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

  function automatic longint bcd_val(input logic [QW-1:0] v, input int nd);
    longint r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [QW-1:0] to_bcd(input longint v);
    logic [QW-1:0] r = '0;
    longint x = v;
    for (int i = 0; i < M_DIG; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int lead_zeros(input logic [TW-1:0] v);
    int z = 0;
    for (int i = N_DIG - 1; i >= 0; i--) begin
      if (v[4*i +: 4] != 4'h0) return z;
      z++;
    end
    return z;
  endfunction

  function automatic logic digits_ok(input logic [QW-1:0] v);
    for (int i = 0; i < M_DIG; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // Start one operation; optionally inject a second start while busy (R5)
  task automatic run_op(input logic [TW-1:0] tv, input logic inject, input logic [TW-1:0] tv2);
    int n;
    longint tval, dval, qexp;
    int z;
    tval = bcd_val(QW'(tv), N_DIG);
    z = lead_zeros(tv);
    @(negedge clk);
    start = 1'b1;
    t_bcd = tv;
    @(negedge clk);
    start = 1'b0;
    t_bcd = '0;
    n = 1;
    if (tval != 0) chk(busy == 1'b1, "R9 busy", longint'(busy), 1);
    while (!done && n <= LAT_MAX + 5) begin
      if (inject && n == 3) begin
        start = 1'b1;
        t_bcd = tv2;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(done == 1'b1 && n <= LAT_MAX, "R7 latency", longint'(n), longint'(LAT_MAX));
    chk(busy == 1'b0, "R4 busy at done", longint'(busy), 0);
    if (tval == 0) begin
      chk(n == 1, "R1 zero cycle", longint'(n), 1);
      chk(zero_err == 1'b1, "R1 flag", longint'(zero_err), 1);
      chk(q_bcd == '0 && shift_exp == '0, "R1 outputs", bcd_val(q_bcd, M_DIG), 0);
    end else begin
      dval = tval * pow10(z);
      qexp = pow10(N_DIG + M_DIG - 2) / dval;
      chk(zero_err == 1'b0, "R9 flag clear", longint'(zero_err), 0);
      chk(int'(shift_exp) == z, "R2 shift", longint'(shift_exp), longint'(z));
      chk(q_bcd == to_bcd(qexp), inject ? "R5 quotient" : "R3 quotient",
          bcd_val(q_bcd, M_DIG), qexp);
      chk(digits_ok(q_bcd), "R8 digits", longint'(q_bcd), 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse", longint'(done), 0);
  endtask

  task automatic check_hold();
    logic [QW-1:0] q0;
    logic [EW-1:0] e0;
    logic z0;
    q0 = q_bcd; e0 = shift_exp; z0 = zero_err;
    t_bcd = 16'h0007;
    repeat (4) @(negedge clk);
    chk(q_bcd == q0 && shift_exp == e0 && zero_err == z0, "R6 hold",
        bcd_val(q_bcd, M_DIG), bcd_val(q0, M_DIG));
    t_bcd = '0;
  endtask

  initial begin
    logic [TW-1:0] rv;
    int unsigned seed;
    seed = $urandom(32'd20250611);
    rst = 1'b1;
    start = 1'b0;
    t_bcd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && zero_err == 1'b0, "R4 reset ctrl", longint'(busy), 0);
    chk(q_bcd == '0 && shift_exp == '0, "R6 reset data", bcd_val(q_bcd, M_DIG), 0);

    run_op(16'h0000, 1'b0, '0);
    check_hold();
    run_op(16'h0001, 1'b0, '0);
    check_hold();
    run_op(16'h9999, 1'b0, '0);
    run_op(16'h1000, 1'b0, '0);
    run_op(16'h0300, 1'b0, '0);
    run_op(16'h0009, 1'b0, '0);
    run_op(16'h1001, 1'b0, '0);
    run_op(16'h0000, 1'b0, '0);
    run_op(16'h0017, 1'b0, '0);
    run_op(16'h0250, 1'b1, 16'h0003);
    check_hold();

    for (int k = 0; k < 60; k++) begin
      rv = '0;
      for (int d = 0; d < N_DIG; d++) rv[4*d +: 4] = 4'($urandom % 10);
      if ($urandom % 3 == 0) rv[TW-1 -: 4] = 4'h0;
      if ($urandom % 5 == 0) rv[TW-5 -: 4] = 4'h0;
      run_op(rv, (k % 7) == 0, 16'h0001);
    end

    finish_run();
  end
endmodule